// File: doc/BRIEF.md
# Sticky Program Status Register

This block holds the status word that a host polls while a page-program engine works. It keeps two live bits: a ready flag that the engine drives low when an operation starts and high when it finishes, and a program-fail flag that the engine can raise but never lower. Only a host clear command lowers the fail flag. Because of this, a host can run a series of page programs and then find out with a single read whether any of them failed. While the fail flag is up, a program-inhibit output tells the command front end to refuse new page-program requests.

Host reads do not see the live bits directly. The block watches two active-low read enables, a chip select and an output enable. It freezes a copy of the live status on the first clock edge at which both enables are sampled low, which is the later of the two falling edges. That copy stays on the status output until the enables are released and asserted again. To see a completion, the host must therefore toggle an enable between polls.

All inputs are synchronous to `clk`. The event inputs are single-cycle pulses. The asynchronous reset is asserted at once and released through a synchronizer.

Top module: `pgm_status_reg`

## Requirements
- R1: While reset is asserted, and after it is released until the first capture, `status_o` reads 0x80 (bit 7 = 1, all other bits 0) and `prog_inhibit_o` is 0.
- R2: Bit 7 of the live status goes to 0 on the clock edge that samples `eng_start_i` and to 1 on the edge that samples `eng_done_i`. When both are sampled on the same edge, start wins and the bit goes to 0.
- R3: Bit 4 of the live status goes to 1 on the edge that samples `eng_fail_i`, whether or not the engine is busy.
- R4: Once set, bit 4 stays at 1 through any number of start and done events until a clear command is sampled.
- R5: A sampled `clr_cmd_i` sets bit 4 to 0. When `eng_fail_i` is sampled on the same edge, bit 4 ends at 1.
- R6: A clear command sampled while the engine is busy (bit 7 = 0), with no done event, clears bit 4 and leaves bit 7 at 0.
- R7: Bits 6, 5 and 3 to 0 of `status_o` always read 0.
- R8: `prog_inhibit_o` is 1 exactly while the live bit 4 is 1. It rises on the edge that samples a fail event and falls on the edge that samples a clear with no fail.
- R9: On the first edge at which `ce_n_i` and `oe_n_i` are both sampled low, `status_o` takes the live status as it stood before that edge. While only one enable is low, `status_o` does not change.
- R10: While both enables stay low, `status_o` holds its value even if the live status changes. A new value appears only after an enable has been sampled high and both are low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_start_i | input | 1 | Engine begins a program operation (pulse) |
| eng_done_i | input | 1 | Engine finished its operation (pulse) |
| eng_fail_i | input | 1 | Engine reports a program failure (pulse) |
| clr_cmd_i | input | 1 | Host clear-status command (pulse) |
| ce_n_i | input | 1 | Active-low chip select for reads |
| oe_n_i | input | 1 | Active-low output enable for reads |
| status_o | output | 8 | Frozen status snapshot: bit 7 ready, bit 4 fail |
| prog_inhibit_o | output | 1 | High while program-fail is latched; refuse new page programs |

## Verification
A wrong fail flag does not show right away. It appears at `prog_inhibit_o` on the cycle after the event, but it only appears on `status_o` at the next fresh capture. For that reason every stimulus step in the bench ends with a complete deselect-and-select read. A ready flag that is stuck or has the wrong priority shows as a bad bit 7 in that same read. A capture that fires on the wrong edge, or one that refreshes while the enables are held low, shows only in the directed sequences. Those sequences change the live status while one or both enables are held low and then sample `status_o` before and after the enable toggle.

// File: rtl/sps_pkg.sv
package sps_pkg;
  parameter int unsigned STAT_W = 8;
  localparam int unsigned RDY_POS  = 7;
  localparam int unsigned FAIL_POS = 4;

  typedef logic [STAT_W-1:0] stat_t;

  localparam stat_t RESET_STAT = stat_t'(1) << RDY_POS;

  function automatic stat_t pack_status(input logic rdy, input logic fail);
    stat_t s;
    s           = '0;
    s[RDY_POS]  = rdy;
    s[FAIL_POS] = fail;
    return s;
  endfunction
endpackage

// File: rtl/sps_rst_sync.sv
module sps_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/sps_state.sv
module sps_state
  import sps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  done_i,
  input  logic  fail_i,
  input  logic  clr_i,
  output logic  rdy_o,
  output logic  fail_o,
  output stat_t live_o
);
  logic rdy_q, rdy_d;
  logic fail_q, fail_d;

  // Ready flag: engine owns both directions; start outranks done.
  always_comb begin
    rdy_d = rdy_q;
    if (start_i)     rdy_d = 1'b0;
    else if (done_i) rdy_d = 1'b1;
  end

  // Fail flag: engine may only set; host clear only lowers; set outranks clear.
  always_comb begin
    fail_d = fail_q;
    if (fail_i)     fail_d = 1'b1;
    else if (clr_i) fail_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b1;
      fail_q <= 1'b0;
    end else begin
      rdy_q  <= rdy_d;
      fail_q <= fail_d;
    end
  end

  assign rdy_o  = rdy_q;
  assign fail_o = fail_q;
  assign live_o = pack_status(rdy_q, fail_q);

  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !rdy_o);
  a_r2_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !start_i) |=> rdy_o);
  a_r3_fail_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fail_i |=> fail_o);
  a_r4_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_o && !clr_i) |=> fail_o);
  a_r5_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !fail_i) |=> !fail_o);
  a_r6_clear_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !rdy_o && !done_i) |=> !rdy_o);
endmodule

// File: rtl/sps_snapshot.sv
module sps_snapshot
  import sps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ce_n_i,
  input  logic  oe_n_i,
  input  stat_t live_i,
  output stat_t snap_o
);
  logic  rd_en, rd_en_q, capture;
  stat_t snap_q, snap_d;

  assign rd_en   = !ce_n_i && !oe_n_i;
  assign capture = rd_en && !rd_en_q;

  always_comb begin
    snap_d = snap_q;
    if (capture) snap_d = live_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      snap_q  <= RESET_STAT;
    end else begin
      rd_en_q <= rd_en;
      snap_q  <= snap_d;
    end
  end

  assign snap_o = snap_q;

  a_r9_capture_live: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_en_q) |=> (snap_o == $past(live_i)));
  a_r9_one_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(snap_o));
  a_r10_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_en_q) |=> $stable(snap_o));
endmodule

// File: rtl/pgm_status_reg.sv
module pgm_status_reg
  import sps_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      eng_start_i,
  input  logic                      eng_done_i,
  input  logic                      eng_fail_i,
  input  logic                      clr_cmd_i,
  input  logic                      ce_n_i,
  input  logic                      oe_n_i,
  output logic [sps_pkg::STAT_W-1:0] status_o,
  output logic                      prog_inhibit_o
);
  logic  rst_n_int;
  logic  rdy, fail;
  stat_t live, snap;

  sps_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .arst_n    (rst_n),
    .rst_n_sync(rst_n_int)
  );

  sps_state u_state (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .start_i(eng_start_i),
    .done_i (eng_done_i),
    .fail_i (eng_fail_i),
    .clr_i  (clr_cmd_i),
    .rdy_o  (rdy),
    .fail_o (fail),
    .live_o (live)
  );

  sps_snapshot u_snap (
    .clk   (clk),
    .rst_n (rst_n_int),
    .ce_n_i(ce_n_i),
    .oe_n_i(oe_n_i),
    .live_i(live),
    .snap_o(snap)
  );

  assign status_o       = snap;
  assign prog_inhibit_o = fail;

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n_int)
    ((status_o & ~(stat_t'(1) << RDY_POS) & ~(stat_t'(1) << FAIL_POS)) == '0));
  a_r8_inhibit_rises: assert property (@(posedge clk) disable iff (!rst_n_int)
    eng_fail_i |=> prog_inhibit_o);
  a_r8_inhibit_falls: assert property (@(posedge clk) disable iff (!rst_n_int)
    (clr_cmd_i && !eng_fail_i) |=> !prog_inhibit_o);
  a_r1_idle_ready: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(rst_n_int) |-> (rdy && !fail));
endmodule

// File: tb/pgm_status_reg_tb.sv
`timescale 1ns/1ps
module pgm_status_reg_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic start, done, fail, clr, ce_n, oe_n;
  logic [7:0] status;
  logic inhibit;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pgm_status_reg u_dut (
    .clk(clk), .rst_n(rst_n),
    .eng_start_i(start), .eng_done_i(done), .eng_fail_i(fail), .clr_cmd_i(clr),
    .ce_n_i(ce_n), .oe_n_i(oe_n),
    .status_o(status), .prog_inhibit_o(inhibit)
  );

  // Fields: {start, done, fail, clr, expected bit7, expected bit4}
  localparam int NV = 15;
  localparam logic [5:0] VEC [NV] = '{
    6'b1000_00, // start: busy (R2)
    6'b0100_10, // done: ready (R2)
    6'b1000_00, // start
    6'b0110_11, // done + fail (R3)
    6'b1000_01, // start, fail sticks (R4)
    6'b0100_11, // done, fail sticks (R4)
    6'b0001_10, // clear (R5)
    6'b0010_11, // fail alone while ready (R3)
    6'b0011_11, // fail + clear same cycle: fail wins (R5)
    6'b0001_10, // clear
    6'b1000_00, // start
    6'b0010_01, // fail while busy (R3)
    6'b0001_00, // clear while busy keeps bit 7 low (R6)
    6'b1100_00, // start + done same cycle: start wins (R2)
    6'b0100_10  // done
  };

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", what, act, exp);
    end
  endtask

  task automatic pulse(input logic s, input logic d, input logic f, input logic c);
    start = s; done = d; fail = f; clr = c;
    @(negedge clk);
    start = 0; done = 0; fail = 0; clr = 0;
  endtask

  task automatic do_read(output logic [7:0] val);
    ce_n = 0; oe_n = 0;
    @(negedge clk);
    val = status;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd;
    logic [7:0] exp_b;
    rst_n = 0; start = 0; done = 0; fail = 0; clr = 0; ce_n = 1; oe_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h80);
    chk("R1 reset inhibit", {7'd0, inhibit}, 8'h00);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 post-reset status", status, 8'h80);
    do_read(rd);
    chk("R1 first read", rd, 8'h80);

    for (int i = 0; i < NV; i++) begin
      pulse(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R8 inhibit vec %0d", i), {7'd0, inhibit}, {7'd0, VEC[i][0]});
      exp_b = {VEC[i][1], 2'b00, VEC[i][0], 4'b0000};
      do_read(rd);
      chk($sformatf("vec %0d (R2 R3 R4 R5 R6 R7)", i), rd, exp_b);
    end

    // R10: held enables freeze the snapshot
    ce_n = 0; oe_n = 0;
    @(negedge clk);
    chk("R10 held capture", status, 8'h80);
    pulse(1, 0, 0, 0);
    @(negedge clk);
    chk("R10 held stays", status, 8'h80);
    ce_n = 1; oe_n = 1;
    @(negedge clk);
    do_read(rd);
    chk("R10 after toggle", rd, 8'h00);

    // R9: capture follows the later of the two enables
    ce_n = 0;
    @(negedge clk);
    pulse(0, 1, 0, 0);
    @(negedge clk);
    chk("R9 one enable no capture", status, 8'h00);
    oe_n = 0;
    @(negedge clk);
    chk("R9 later enable captures", status, 8'h80);
    ce_n = 1; oe_n = 1;
    @(negedge clk);
    oe_n = 0;
    @(negedge clk);
    pulse(0, 0, 1, 0);
    chk("R9 oe-first no capture", status, 8'h80);
    ce_n = 0;
    @(negedge clk);
    chk("R9 ce-later captures", status, 8'h90);
    ce_n = 1; oe_n = 1;
    @(negedge clk);
    chk("R8 inhibit set", {7'd0, inhibit}, 8'h01);

    // R1: reset mid-run restores power-up state
    rst_n = 0;
    #1;
    chk("R1 async reset status", status, 8'h80);
    chk("R1 async reset inhibit", {7'd0, inhibit}, 8'h00);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    do_read(rd);
    chk("R1 read after reset", rd, 8'h80);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule